// File: doc/BRIEF.md
# Halfword Storage Byte-Lane Port

This block connects a processor-side request port to a synchronous storage array whose rows are two bytes wide, each byte kept with its own parity bit. The processor presents a 17-bit byte address, so any of 131,072 bytes can be reached in one access. The array is indexed only by the upper sixteen address bits. The lowest address bit never reaches the array. It only decides which byte lane a byte access uses. Within a row the lower byte address is the high-order byte.

On a write the block computes one odd-parity bit per byte. A byte write is issued as a lane-enabled write, so the other byte of the row and its parity bit are left alone and no read-modify-write cycle is needed. On a read the block checks both stored bytes. It returns either the whole halfword or, for a byte access, the addressed byte moved to the low lane, together with per-byte parity error flags. Requests follow a req/ack handshake with one request in flight. Read data arrives the cycle after ack.

Top module: `hword_lane_port`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `ack_o`, `rvalid_o` and `mem_en_o` are 0.
- R2: A request seen at a clock edge while the block is idle produces `ack_o` for exactly one cycle in the following cycle. In that same cycle `mem_en_o` is 1 and `mem_row_o` equals `addr_i[16:1]`.
- R3: `rvalid_o` is 1 for exactly the one cycle after the `ack_o` of a read, and it is never raised for a write.
- R4: A halfword read returns the byte at the even address (address bit 0 = 0) in `rdata_o[15:8]` and the byte at the odd address in `rdata_o[7:0]`.
- R5: A byte read returns the addressed byte in `rdata_o[7:0]` with `rdata_o[15:8]` = 0. Address bit 0 = 0 selects the high-order stored byte, and 1 selects the low-order byte.
- R6: On every write `mem_wdata_o` is laid out as {parity, high byte, parity, low byte} (bits 17, 16:9, 8, 7:0). Each enabled 9-bit lane holds an odd number of ones.
- R7: A byte write takes its data from `wdata_i[7:0]` and raises only the addressed lane's enable. `mem_be_o[1]` is used for address bit 0 = 0 and `mem_be_o[0]` for address bit 0 = 1. The other stored byte reads back unchanged. A halfword write raises both enables.
- R8: On a halfword read `perr_o[1]` flags a parity failure of the high-order stored byte and `perr_o[0]` one of the low-order byte.
- R9: On a byte read only the selected byte's parity result is reported, in `perr_o[0]`, and `perr_o[1]` is 0. A parity failure in the unselected byte is not reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Access request, held until `ack_o` |
| wr_i | input | 1 | 1 = write, 0 = read |
| byte_i | input | 1 | 1 = byte access, 0 = halfword access |
| addr_i | input | 17 | Byte address |
| wdata_i | input | 16 | Write data; byte writes use bits 7:0 |
| ack_o | output | 1 | Request accepted and issued to the array |
| rvalid_o | output | 1 | Read data and error flags valid |
| rdata_o | output | 16 | Read data |
| perr_o | output | 2 | Per-byte parity error flags |
| mem_en_o | output | 1 | Array access strobe |
| mem_wr_o | output | 1 | Array write strobe |
| mem_be_o | output | 2 | Array lane enables, bit 1 = high-order byte |
| mem_row_o | output | 16 | Array row address |
| mem_wdata_o | output | 18 | Array write data with parity |
| mem_rdata_i | input | 18 | Array read data, valid the cycle after a read strobe |

## Verification
The assertions assume a well-behaved requester. It holds `req_i`, `wr_i`, `byte_i`, `addr_i` and `wdata_i` steady from the request until it has seen `ack_o`, and it keeps only one request open. They also assume the array returns the addressed row the cycle after a read strobe. The stimulus respects this by changing inputs only on the falling edge. It drops the request on the same falling edge at which it observes `ack_o`, and it issues the next request only after the response cycle has passed. Parity faults are injected directly into the bench's array model between accesses, never in the same cycle as an access to that row.

// File: rtl/hwl_pkg.sv
// Package: shared types for the halfword byte-lane storage port.
// Assumes nothing beyond being compiled before the modules that import it.
package hwl_pkg;

    // Phase of the single in-flight access.
    typedef enum logic [1:0] {
        HWL_IDLE   = 2'd0,
        HWL_ACCESS = 2'd1,
        HWL_RESP   = 2'd2
    } hwl_phase_e;

endpackage

// File: rtl/hwl_parity_gen.sv
// Module: builds the stored cell from write data, one odd-parity bit per byte lane.
// Assumes lane g occupies bits [g*(BYTE_W+1) +: BYTE_W+1] with parity as its top bit.
module hwl_parity_gen #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 2
) (
    input  logic [LANES*BYTE_W-1:0]     data_i,
    output logic [LANES*(BYTE_W+1)-1:0] cell_o
);
    localparam int SLOT_W = BYTE_W + 1;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            // Append the odd-parity bit above this lane's byte.
            assign cell_o[g*SLOT_W +: SLOT_W] =
                {~^data_i[g*BYTE_W +: BYTE_W], data_i[g*BYTE_W +: BYTE_W]};
        end
    endgenerate

endmodule

// File: rtl/hwl_parity_chk.sv
// Module: splits a stored cell into data bytes and per-lane odd-parity failure flags.
// Assumes the same cell layout as hwl_parity_gen.
module hwl_parity_chk #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 2
) (
    input  logic [LANES*(BYTE_W+1)-1:0] cell_i,
    output logic [LANES*BYTE_W-1:0]     data_o,
    output logic [LANES-1:0]            err_o
);
    localparam int SLOT_W = BYTE_W + 1;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            // Strip parity and flag a lane whose nine bits hold an even count of ones.
            assign data_o[g*BYTE_W +: BYTE_W] = cell_i[g*SLOT_W +: BYTE_W];
            assign err_o[g] = ~(^cell_i[g*SLOT_W +: SLOT_W]);
        end
    endgenerate

endmodule

// File: rtl/hwl_write_lanes.sv
// Module: forms lane enables and lane data for halfword and byte writes.
// Assumes LANES is a power of two, at least 2, and big-endian byte order
// (byte offset 0 maps to the most significant lane).
module hwl_write_lanes #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 2
) (
    input  logic                       byte_mode_i,
    input  logic [$clog2(LANES)-1:0]   off_i,
    input  logic [LANES*BYTE_W-1:0]    wdata_i,
    output logic [LANES-1:0]           be_o,
    output logic [LANES*BYTE_W-1:0]    lane_data_o
);
    localparam int SEL_W = $clog2(LANES);

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            // Enable every lane for a halfword, only the addressed lane for a byte.
            assign be_o[g] = !byte_mode_i || (off_i == SEL_W'(LANES - 1 - g));
            // A byte write replicates the low input byte onto every lane.
            assign lane_data_o[g*BYTE_W +: BYTE_W] =
                byte_mode_i ? wdata_i[BYTE_W-1:0] : wdata_i[g*BYTE_W +: BYTE_W];
        end
    endgenerate

endmodule

// File: rtl/hwl_read_steer.sv
// Module: delivers a whole halfword, or moves the addressed byte and its error flag to lane 0.
// Assumes big-endian byte order within the row, as in hwl_write_lanes.
module hwl_read_steer #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 2
) (
    input  logic                      byte_mode_i,
    input  logic [$clog2(LANES)-1:0]  off_i,
    input  logic [LANES*BYTE_W-1:0]   data_i,
    input  logic [LANES-1:0]          err_i,
    output logic [LANES*BYTE_W-1:0]   rdata_o,
    output logic [LANES-1:0]          perr_o
);
    localparam int SEL_W = $clog2(LANES);

    logic [SEL_W-1:0]  lane_sel;
    logic [BYTE_W-1:0] pick_data;
    logic              pick_err;

    // Translate the byte offset into the lane index it lives in.
    assign lane_sel = SEL_W'(LANES - 1) - off_i;

    // Choose the addressed lane, then pick the halfword or byte form of the result.
    always_comb begin
        pick_data = '0;
        pick_err  = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (SEL_W'(i) == lane_sel) begin
                pick_data = data_i[i*BYTE_W +: BYTE_W];
                pick_err  = err_i[i];
            end
        end
        if (byte_mode_i) begin
            rdata_o               = '0;
            rdata_o[BYTE_W-1:0]   = pick_data;
            perr_o                = '0;
            perr_o[0]             = pick_err;
        end else begin
            rdata_o = data_i;
            perr_o  = err_i;
        end
    end

endmodule

// File: rtl/hword_lane_port.sv
// Module: top of the halfword byte-lane storage port. Accepts one request at a time,
// issues it to the array the cycle after acceptance (with ack), and presents read
// data the cycle after that.
// Assumes the requester holds its request fields until ack and that the array
// returns the addressed row one cycle after a read strobe.
module hword_lane_port
    import hwl_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int BYTE_W = 8,
    parameter int LANES  = 2
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   req_i,
    input  logic                                   wr_i,
    input  logic                                   byte_i,
    input  logic [ADDR_W-1:0]                      addr_i,
    input  logic [LANES*BYTE_W-1:0]                wdata_i,
    output logic                                   ack_o,
    output logic                                   rvalid_o,
    output logic [LANES*BYTE_W-1:0]                rdata_o,
    output logic [LANES-1:0]                       perr_o,
    output logic                                   mem_en_o,
    output logic                                   mem_wr_o,
    output logic [LANES-1:0]                       mem_be_o,
    output logic [ADDR_W-$clog2(LANES)-1:0]        mem_row_o,
    output logic [LANES*(BYTE_W+1)-1:0]            mem_wdata_o,
    input  logic [LANES*(BYTE_W+1)-1:0]            mem_rdata_i
);
    localparam int SEL_W  = $clog2(LANES);
    localparam int ROW_W  = ADDR_W - SEL_W;
    localparam int DATA_W = LANES * BYTE_W;
    localparam int CELL_W = LANES * (BYTE_W + 1);

    typedef struct packed {
        logic              wr;
        logic              byte_mode;
        logic [SEL_W-1:0]  off;
        logic [ROW_W-1:0]  row;
        logic [DATA_W-1:0] wdata;
    } hwl_cmd_t;

    hwl_phase_e        phase_q, phase_d;
    hwl_cmd_t          cmd_q;
    logic [LANES-1:0]  lane_be;
    logic [DATA_W-1:0] lane_data;
    logic [DATA_W-1:0] rd_data;
    logic [LANES-1:0]  rd_err;
    logic [DATA_W-1:0] steer_data;
    logic [LANES-1:0]  steer_err;
    logic              in_access;
    logic              in_resp;

    // Advance the access phase: idle -> access -> (response for reads) -> idle.
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            HWL_IDLE:   if (req_i) phase_d = HWL_ACCESS;
            HWL_ACCESS: phase_d = cmd_q.wr ? HWL_IDLE : HWL_RESP;
            HWL_RESP:   phase_d = HWL_IDLE;
            default:    phase_d = HWL_IDLE;
        endcase
    end

    // Hold the phase register under synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= HWL_IDLE;
        else        phase_q <= phase_d;
    end

    // Capture the request fields when a request is accepted from idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (phase_q == HWL_IDLE && req_i) begin
            cmd_q.wr        <= wr_i;
            cmd_q.byte_mode <= byte_i;
            cmd_q.off       <= addr_i[SEL_W-1:0];
            cmd_q.row       <= addr_i[ADDR_W-1:SEL_W];
            cmd_q.wdata     <= wdata_i;
        end
    end

    assign in_access = (phase_q == HWL_ACCESS);
    assign in_resp   = (phase_q == HWL_RESP);

    hwl_write_lanes #(.BYTE_W(BYTE_W), .LANES(LANES)) i_wr_lanes (
        .byte_mode_i (cmd_q.byte_mode),
        .off_i       (cmd_q.off),
        .wdata_i     (cmd_q.wdata),
        .be_o        (lane_be),
        .lane_data_o (lane_data)
    );

    hwl_parity_gen #(.BYTE_W(BYTE_W), .LANES(LANES)) i_par_gen (
        .data_i (lane_data),
        .cell_o (mem_wdata_o)
    );

    hwl_parity_chk #(.BYTE_W(BYTE_W), .LANES(LANES)) i_par_chk (
        .cell_i (mem_rdata_i),
        .data_o (rd_data),
        .err_o  (rd_err)
    );

    hwl_read_steer #(.BYTE_W(BYTE_W), .LANES(LANES)) i_rd_steer (
        .byte_mode_i (cmd_q.byte_mode),
        .off_i       (cmd_q.off),
        .data_i      (rd_data),
        .err_i       (rd_err),
        .rdata_o     (steer_data),
        .perr_o      (steer_err)
    );

    // Drive the array strobes during the access phase only.
    assign ack_o     = in_access;
    assign mem_en_o  = in_access;
    assign mem_wr_o  = in_access && cmd_q.wr;
    assign mem_be_o  = (in_access && cmd_q.wr) ? lane_be : '0;
    assign mem_row_o = cmd_q.row;

    // Present read results in the response phase, zero otherwise.
    assign rvalid_o = in_resp;
    assign rdata_o  = in_resp ? steer_data : '0;
    assign perr_o   = in_resp ? steer_err  : '0;

endmodule

// File: rtl/hword_lane_port_chk.sv
// Module: property checker for hword_lane_port, attached by bind below.
// Assumes requester fields are steady from request to ack and one request is open at a time.
module hword_lane_port_chk #(
    parameter int ADDR_W = 17,
    parameter int BYTE_W = 8,
    parameter int LANES  = 2
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic                               req_i,
    input logic                               wr_i,
    input logic                               byte_i,
    input logic [ADDR_W-$clog2(LANES)-1:0]    row_req_i,
    input logic                               ack_o,
    input logic                               rvalid_o,
    input logic [LANES-1:0]                   perr_o,
    input logic                               mem_en_o,
    input logic                               mem_wr_o,
    input logic [LANES-1:0]                   mem_be_o,
    input logic [ADDR_W-$clog2(LANES)-1:0]    mem_row_o,
    input logic [LANES*(BYTE_W+1)-1:0]        mem_wdata_o
);
    localparam int SLOT_W = BYTE_W + 1;

    // R2
    ack_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> $past(req_i));

    // R2
    ack_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);

    // R2
    row_matches_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> (mem_en_o && mem_row_o == $past(row_req_i)));

    // R3
    rvalid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o |-> ($past(ack_o) && !$past(mem_wr_o)));

    // R3
    no_rvalid_for_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && mem_wr_o) |=> !rvalid_o);

    // R7
    byte_write_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_o && $past(byte_i) && $past(wr_i)) |-> ($countones(mem_be_o) == 1));

    // R9
    byte_read_upper_err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid_o && $past(byte_i, 2)) |-> (perr_o[LANES-1:1] == '0));

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            // R6
            wr_lane_odd_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (mem_en_o && mem_wr_o && mem_be_o[g]) |-> (^mem_wdata_o[g*SLOT_W +: SLOT_W]));
        end
    endgenerate

endmodule

bind hword_lane_port hword_lane_port_chk #(
    .ADDR_W (ADDR_W),
    .BYTE_W (BYTE_W),
    .LANES  (LANES)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .wr_i        (wr_i),
    .byte_i      (byte_i),
    .row_req_i   (addr_i[ADDR_W-1:$clog2(LANES)]),
    .ack_o       (ack_o),
    .rvalid_o    (rvalid_o),
    .perr_o      (perr_o),
    .mem_en_o    (mem_en_o),
    .mem_wr_o    (mem_wr_o),
    .mem_be_o    (mem_be_o),
    .mem_row_o   (mem_row_o),
    .mem_wdata_o (mem_wdata_o)
);

// File: tb/test_hword_lane_port.sv
// Bench: scoreboard test of hword_lane_port with a small synchronous array model.
module test_hword_lane_port;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req, wr, byt;
    logic [16:0] addr;
    logic [15:0] wdata;
    logic        ack, rvalid;
    logic [15:0] rdata;
    logic [1:0]  perr;
    logic        mem_en, mem_wr;
    logic [1:0]  mem_be;
    logic [15:0] mem_row;
    logic [17:0] mem_wdata;
    logic [17:0] mem_rdata;

    // Fault injection into the array model.
    logic        inj_en;
    logic [7:0]  inj_row;
    logic [17:0] inj_mask;

    logic [17:0] mem [256];

    // Reference contents: stored byte per row and lane (lane 1 = high-order), and parity state.
    logic [7:0] ref_b [256][2];
    bit         ref_e [256][2];

    typedef struct {
        logic [15:0] data;
        logic [1:0]  perr;
        string       rq;
    } exp_t;
    exp_t sb_q[$];

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hword_lane_port i_hword_lane_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req),
        .wr_i        (wr),
        .byte_i      (byt),
        .addr_i      (addr),
        .wdata_i     (wdata),
        .ack_o       (ack),
        .rvalid_o    (rvalid),
        .rdata_o     (rdata),
        .perr_o      (perr),
        .mem_en_o    (mem_en),
        .mem_wr_o    (mem_wr),
        .mem_be_o    (mem_be),
        .mem_row_o   (mem_row),
        .mem_wdata_o (mem_wdata),
        .mem_rdata_i (mem_rdata)
    );

    // Synchronous array model: lane-enabled writes, registered reads, fault injection.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= '0;
            mem_rdata <= '0;
        end else begin
            if (inj_en) mem[inj_row] <= mem[inj_row] ^ inj_mask;
            if (mem_en) begin
                if (mem_wr) begin
                    for (int l = 0; l < 2; l++)
                        if (mem_be[l]) mem[mem_row[7:0]][l*9 +: 9] <= mem_wdata[l*9 +: 9];
                end else begin
                    mem_rdata <= mem[mem_row[7:0]];
                end
            end
        end
    end

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // Monitor: compare each read response with the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && rvalid) begin
            if (sb_q.size() == 0) begin
                chk("R3 unexpected rvalid", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk({e.rq, " data"}, {16'h0, rdata}, {16'h0, e.data});
                chk({e.rq, " perr"}, {30'h0, perr}, {30'h0, e.perr});
            end
        end
    end

    // Driver: one access through the handshake, with port checks and scoreboard push.
    task automatic access(input bit w, input bit b, input logic [16:0] a,
                          input logic [15:0] wd, input string rq);
        logic [7:0] r8;
        int         ln;
        logic [1:0] exp_be;
        r8 = a[8:1];
        ln = a[0] ? 0 : 1;
        @(negedge clk);
        req = 1'b1; wr = w; byt = b; addr = a; wdata = wd;
        if (!w) begin
            exp_t e;
            e.rq = rq;
            if (b) begin
                e.data = {8'h00, ref_b[r8][ln]};
                e.perr = {1'b0, ref_e[r8][ln]};
            end else begin
                e.data = {ref_b[r8][1], ref_b[r8][0]};
                e.perr = {ref_e[r8][1], ref_e[r8][0]};
            end
            sb_q.push_back(e);
        end
        @(negedge clk);
        chk("R2 ack", {31'h0, ack}, 32'd1);
        chk("R2 mem_row", {16'h0, mem_row}, {16'h0, a[16:1]});
        if (w) begin
            exp_be = b ? (a[0] ? 2'b01 : 2'b10) : 2'b11;
            chk("R7 mem_be", {30'h0, mem_be}, {30'h0, exp_be});
            for (int l = 0; l < 2; l++) begin
                if (exp_be[l]) begin
                    logic [7:0] byte_v;
                    byte_v = b ? wd[7:0] : wd[l*8 +: 8];
                    chk("R6 lane cell", {23'h0, mem_wdata[l*9 +: 9]}, {23'h0, ~^byte_v, byte_v});
                    ref_b[r8][l] = byte_v;
                    ref_e[r8][l] = 1'b0;
                end
            end
        end
        req = 1'b0;
        @(negedge clk);
        chk("R2 ack drops", {31'h0, ack}, 32'd0);
        if (w) chk("R3 no rvalid on write", {31'h0, rvalid}, 32'd0);
    endtask

    // Flip bit 0 of one stored byte without fixing its parity.
    task automatic inject(input logic [7:0] r8, input int ln);
        @(negedge clk);
        inj_en = 1'b1; inj_row = r8; inj_mask = 18'h1 << (ln * 9);
        @(negedge clk);
        inj_en = 1'b0;
        ref_b[r8][ln] = ref_b[r8][ln] ^ 8'h01;
        ref_e[r8][ln] = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R2 watchdog: actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        req = 0; wr = 0; byt = 0; addr = '0; wdata = '0;
        inj_en = 0; inj_row = '0; inj_mask = '0;
        rst_n = 1'b0;
        for (int i = 0; i < 256; i++) begin
            ref_b[i][0] = 8'h00; ref_b[i][1] = 8'h00;
            ref_e[i][0] = 1'b1;  ref_e[i][1] = 1'b1;
        end
        repeat (3) @(negedge clk);
        // R1: quiet outputs during reset
        chk("R1 ack in reset", {31'h0, ack}, 32'd0);
        chk("R1 rvalid in reset", {31'h0, rvalid}, 32'd0);
        chk("R1 mem_en in reset", {31'h0, mem_en}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ack after reset", {31'h0, ack}, 32'd0);
        chk("R1 mem_en after reset", {31'h0, mem_en}, 32'd0);

        // R4, R6: halfword write and read back
        access(1, 0, 17'h00010, 16'hA53C, "R6 hw write");
        access(0, 0, 17'h00010, 16'h0000, "R4 hw read");
        // R5: byte reads from both lanes
        access(0, 1, 17'h00011, 16'h0000, "R5 byte read odd");
        access(0, 1, 17'h00010, 16'h0000, "R5 byte read even");
        // R7: byte writes keep the other byte
        access(1, 1, 17'h00011, 16'hFF77, "R7 byte write odd");
        access(0, 0, 17'h00010, 16'h0000, "R7 readback after odd write");
        access(1, 1, 17'h00010, 16'h5500, "R7 byte write even");
        access(0, 0, 17'h00010, 16'h0000, "R7 readback after even write");
        // R2, R5: top of the address range
        access(1, 0, 17'h1FFFE, 16'h0102, "R2 hw write top");
        access(0, 1, 17'h1FFFF, 16'h0000, "R5 byte read top odd");
        access(0, 1, 17'h1FFFE, 16'h0000, "R5 byte read top even");
        // R8, R9: parity faults in the high-order byte, then both
        inject(8'h08, 1);
        access(0, 0, 17'h00010, 16'h0000, "R8 hw read high fault");
        access(0, 1, 17'h00011, 16'h0000, "R9 byte read clean lane");
        access(0, 1, 17'h00010, 16'h0000, "R9 byte read faulty lane");
        inject(8'h08, 0);
        access(0, 0, 17'h00010, 16'h0000, "R8 hw read both faults");
        access(0, 1, 17'h00011, 16'h0000, "R9 byte read low fault");
        // R7: a byte write repairs one lane only
        access(1, 1, 17'h00011, 16'h0033, "R7 byte write repair");
        access(0, 0, 17'h00010, 16'h0000, "R8 hw read one fault left");
        // R4, R6: several data patterns
        for (int k = 0; k < 6; k++) begin
            logic [15:0] v;
            logic [16:0] a;
            v = (k == 0) ? 16'hFFFF : (k == 1) ? 16'h0000 : 16'(k * 16'h1357) ^ 16'hF0F0;
            a = 17'(17'h00080 + 17'(k * 2));
            access(1, 0, a, v, "R6 pattern write");
            access(0, 0, a, 16'h0000, "R4 pattern read");
            access(0, 1, a | 17'h1, 16'h0000, "R5 pattern byte read");
        end

        done = 1'b1;
        repeat (3) @(negedge clk);
        chk("R3 all reads answered", 32'(sb_q.size()), 32'd0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule